// File: doc/BRIEF.md
# Bus slave address decoder

This block is the address and command front end of a slave board on an asynchronous parallel system bus. It compares a nibble of the bus address with a base value set by configuration straps, which places the board on a 16-byte boundary. On a match it turns three further address bits into one of eight active-low device selects. The lowest address bit passes straight through as a control/data line, so the board answers at sixteen device addresses.

The board runs in one of two modes. In direct I/O mode only the I/O read and I/O write commands count. In memory-mapped mode the memory read and memory write commands also count, but only when the upper address byte is all ones, which puts the devices in the top 256 bytes of memory. That upper-byte window can also pull down a RAM-inhibit line, a ROM-inhibit line, or both, each one enabled by its own configuration bit, so that ordinary memory in the window stays silent.

The decode path has no registers, so every output follows its inputs within the same cycle. The clock and reset inputs only time the embedded checks.

Top module: `slave_addr_front`

## Requirements
- R1: The board matches its base only when address bits 7..4 equal `base_cfg`. No device select, read enable or board enable is asserted on a mismatch.
- R2: When the base matches and a merged command is active, exactly one select goes low: `dev_sel_n[k]` with k equal to address bits 3..1. Bit k of `dev_sel_n` is select k. In every other case all eight selects are high.
- R3: `ctl_data` always equals address bit 0.
- R4: When `mmio_mode` is 0, the memory read and memory write commands have no effect on any output.
- R5: When `mmio_mode` is 1, the memory read and memory write commands count only when address bits 15..8 are all ones. A count command joins the I/O command of the same direction.
- R6: The I/O read and I/O write commands count in both modes, whatever the upper address byte.
- R7: `rd_en` (active high) is the merged read qualified by the base match. `buf_to_bus` equals `rd_en`.
- R8: `wr_en` (active high) is the merged write and does not depend on the base match.
- R9: `board_en_n` and `buf_cs_n` are low exactly when a merged command is active and the base matches.
- R10: `inh_ram_n` is low exactly when `mmio_mode` is 1, address bits 15..8 are all ones and `inh_ram_en` is 1. `inh_rom_n` works the same way with `inh_rom_en`. Neither is ever low in direct I/O mode.
- R11: Every output settles from its inputs with no clock edge in between.
- R12: At most one device select is low at any time, and none is low while both merged commands are idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock that times the embedded checks only |
| rst | input | 1 | Synchronous active-high reset of the checks |
| addr | input | 16 | Bus address |
| mem_rd_n | input | 1 | Memory read command, active low |
| mem_wr_n | input | 1 | Memory write command, active low |
| io_rd_n | input | 1 | I/O read command, active low |
| io_wr_n | input | 1 | I/O write command, active low |
| base_cfg | input | 4 | Strap value compared with address bits 7..4 |
| mmio_mode | input | 1 | 1 selects memory-mapped mode, 0 selects direct I/O |
| inh_ram_en | input | 1 | Enables the RAM-inhibit output |
| inh_rom_en | input | 1 | Enables the ROM-inhibit output |
| dev_sel_n | output | 8 | Device selects, active low, bit k is device k |
| ctl_data | output | 1 | Control/data line, copy of address bit 0 |
| rd_en | output | 1 | Internal read enable, active high |
| wr_en | output | 1 | Internal write enable, active high, not base-qualified |
| board_en_n | output | 1 | Board enable that gates the acknowledge drivers, active low |
| buf_to_bus | output | 1 | Data buffer direction, 1 drives toward the bus |
| buf_cs_n | output | 1 | Data buffer chip select, active low |
| inh_ram_n | output | 1 | RAM inhibit, active low |
| inh_rom_n | output | 1 | ROM inhibit, active low |

## Verification
The bench goes after the edges of the memory window. An upper byte of 0xFE must block a memory write, while a memory read in direct mode must be ignored even with 0xFF on top. A design that checked only part of the upper byte, or honoured memory commands in direct mode, would raise a select or an inhibit there. A write on a base miss must still raise `wr_en` but no select and no board enable. A design that qualified the write, or left the selects unqualified, shows up on that one vector. Sweeps over all sixteen base nibbles and all eight select indices catch a shifted bit field or a select that is not one-hot.

// File: rtl/adrdec_pkg.sv
package adrdec_pkg;
    localparam int ADDR_W_DEF   = 16;
    localparam int SEL_BITS_DEF = 3;
    localparam int BASE_W_DEF   = 4;

    typedef struct packed {
        logic rd;
        logic wr;
    } bus_cmd_t;

    // Join I/O and memory commands (active high here); memory ones need the window.
    function automatic bus_cmd_t merge_cmd(input logic io_rd, input logic io_wr,
                                           input logic mem_rd, input logic mem_wr,
                                           input logic mem_ok);
        bus_cmd_t c;
        c.rd = io_rd | (mem_rd & mem_ok);
        c.wr = io_wr | (mem_wr & mem_ok);
        return c;
    endfunction

    function automatic logic cmd_any(input bus_cmd_t c);
        return c.rd | c.wr;
    endfunction
endpackage

// File: rtl/adr_window_match.sv
module adr_window_match #(
    parameter int ADDR_W   = adrdec_pkg::ADDR_W_DEF,
    parameter int SEL_BITS = adrdec_pkg::SEL_BITS_DEF,
    parameter int BASE_W   = adrdec_pkg::BASE_W_DEF
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic [BASE_W-1:0] base_cfg,
    output logic              base_hit,
    output logic              upper_hit
);
    localparam int BASE_LO = SEL_BITS + 1;
    localparam int UP_LO   = BASE_LO + BASE_W;

    assign base_hit  = (addr[UP_LO-1:BASE_LO] == base_cfg);
    assign upper_hit = &addr[ADDR_W-1:UP_LO];
endmodule

// File: rtl/adr_cmd_merge.sv
module adr_cmd_merge
    import adrdec_pkg::*;
(
    input  logic     mem_rd_n,
    input  logic     mem_wr_n,
    input  logic     io_rd_n,
    input  logic     io_wr_n,
    input  logic     mmio_mode,
    input  logic     upper_hit,
    output logic     mem_window,
    output bus_cmd_t cmd
);
    assign mem_window = mmio_mode & upper_hit;
    assign cmd = merge_cmd(!io_rd_n, !io_wr_n, !mem_rd_n, !mem_wr_n, mem_window);
endmodule

// File: rtl/adr_dev_decode.sv
module adr_dev_decode #(
    parameter int SEL_BITS = adrdec_pkg::SEL_BITS_DEF
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic [SEL_BITS-1:0]    idx,
    input  logic                   en,
    output logic [(1<<SEL_BITS)-1:0] sel_n
);
    localparam int NSEL = 1 << SEL_BITS;

    for (genvar g = 0; g < NSEL; g++) begin : g_sel
        assign sel_n[g] = !(en && (idx == SEL_BITS'(g)));
    end

    // R12
    sel_onehot_chk: assert property (@(posedge clk) disable iff (rst)
        $onehot0(~sel_n));
endmodule

// File: rtl/slave_addr_front.sv
module slave_addr_front
    import adrdec_pkg::*;
#(
    parameter int ADDR_W   = ADDR_W_DEF,
    parameter int SEL_BITS = SEL_BITS_DEF,
    parameter int BASE_W   = BASE_W_DEF
) (
    input  logic                      clk,
    input  logic                      rst,
    input  logic [ADDR_W-1:0]         addr,
    input  logic                      mem_rd_n,
    input  logic                      mem_wr_n,
    input  logic                      io_rd_n,
    input  logic                      io_wr_n,
    input  logic [BASE_W-1:0]         base_cfg,
    input  logic                      mmio_mode,
    input  logic                      inh_ram_en,
    input  logic                      inh_rom_en,
    output logic [(1<<SEL_BITS)-1:0]  dev_sel_n,
    output logic                      ctl_data,
    output logic                      rd_en,
    output logic                      wr_en,
    output logic                      board_en_n,
    output logic                      buf_to_bus,
    output logic                      buf_cs_n,
    output logic                      inh_ram_n,
    output logic                      inh_rom_n
);
    localparam int UP_LO = SEL_BITS + 1 + BASE_W;

    logic     base_hit;
    logic     upper_hit;
    logic     mem_window;
    logic     board_on;
    bus_cmd_t cmd;

    adr_window_match #(.ADDR_W(ADDR_W), .SEL_BITS(SEL_BITS), .BASE_W(BASE_W)) u_match (
        .addr      (addr),
        .base_cfg  (base_cfg),
        .base_hit  (base_hit),
        .upper_hit (upper_hit)
    );

    adr_cmd_merge u_merge (
        .mem_rd_n   (mem_rd_n),
        .mem_wr_n   (mem_wr_n),
        .io_rd_n    (io_rd_n),
        .io_wr_n    (io_wr_n),
        .mmio_mode  (mmio_mode),
        .upper_hit  (upper_hit),
        .mem_window (mem_window),
        .cmd        (cmd)
    );

    assign board_on = cmd_any(cmd) & base_hit;

    adr_dev_decode #(.SEL_BITS(SEL_BITS)) u_dec (
        .clk   (clk),
        .rst   (rst),
        .idx   (addr[SEL_BITS:1]),
        .en    (board_on),
        .sel_n (dev_sel_n)
    );

    assign ctl_data   = addr[0];
    assign rd_en      = cmd.rd & base_hit;
    assign wr_en      = cmd.wr;
    assign board_en_n = !board_on;
    assign buf_cs_n   = !board_on;
    assign buf_to_bus = rd_en;
    assign inh_ram_n  = !(mem_window & inh_ram_en);
    assign inh_rom_n  = !(mem_window & inh_rom_en);

    // R2
    sel_needs_board_chk: assert property (@(posedge clk) disable iff (rst)
        (dev_sel_n != '1) |-> !board_en_n);
    // R9
    board_has_cmd_chk: assert property (@(posedge clk) disable iff (rst)
        !board_en_n |-> (rd_en || wr_en));
    // R7
    rd_opens_board_chk: assert property (@(posedge clk) disable iff (rst)
        rd_en |-> (!board_en_n && buf_to_bus && !buf_cs_n));
    // R4
    direct_mem_ignored_chk: assert property (@(posedge clk) disable iff (rst)
        (!mmio_mode && io_rd_n && io_wr_n) |-> (!rd_en && !wr_en && board_en_n));
    // R8
    io_write_passes_chk: assert property (@(posedge clk) disable iff (rst)
        !io_wr_n |-> wr_en);
    // R10
    inhibit_window_chk: assert property (@(posedge clk) disable iff (rst)
        (!inh_ram_n || !inh_rom_n) |-> (mmio_mode && (&addr[ADDR_W-1:UP_LO])));
endmodule

// File: tb/tb_slave_addr_front.sv
module tb_slave_addr_front;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [15:0] addr = '0;
    logic        mem_rd_n = 1'b1, mem_wr_n = 1'b1, io_rd_n = 1'b1, io_wr_n = 1'b1;
    logic [3:0]  base_cfg = 4'h5;
    logic        mmio_mode = 1'b0, inh_ram_en = 1'b0, inh_rom_en = 1'b0;
    logic [7:0]  dev_sel_n;
    logic        ctl_data, rd_en, wr_en, board_en_n, buf_to_bus, buf_cs_n, inh_ram_n, inh_rom_n;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    always #10 clk = ~clk;

    slave_addr_front dut (
        .clk(clk), .rst(rst), .addr(addr),
        .mem_rd_n(mem_rd_n), .mem_wr_n(mem_wr_n), .io_rd_n(io_rd_n), .io_wr_n(io_wr_n),
        .base_cfg(base_cfg), .mmio_mode(mmio_mode),
        .inh_ram_en(inh_ram_en), .inh_rom_en(inh_rom_en),
        .dev_sel_n(dev_sel_n), .ctl_data(ctl_data), .rd_en(rd_en), .wr_en(wr_en),
        .board_en_n(board_en_n), .buf_to_bus(buf_to_bus), .buf_cs_n(buf_cs_n),
        .inh_ram_n(inh_ram_n), .inh_rom_n(inh_rom_n)
    );

    // stimulus: {addr, mem_rd_n, mem_wr_n, io_rd_n, io_wr_n, base, mmio, ram_en, rom_en}
    localparam int NV = 13;
    localparam logic [26:0] STIM [NV] = '{
        {16'h0050, 4'b1111, 4'h5, 3'b000},
        {16'h0056, 4'b1101, 4'h5, 3'b000},
        {16'h005F, 4'b1110, 4'h5, 3'b000},
        {16'h0066, 4'b1101, 4'h5, 3'b000},
        {16'h0031, 4'b1110, 4'h5, 3'b000},
        {16'hFF52, 4'b0111, 4'h5, 3'b011},
        {16'hFF52, 4'b0111, 4'h5, 3'b100},
        {16'hFE54, 4'b1011, 4'h5, 3'b111},
        {16'hFF5B, 4'b1011, 4'h5, 3'b110},
        {16'hFFA0, 4'b1111, 4'h5, 3'b101},
        {16'h1250, 4'b1101, 4'h5, 3'b111},
        {16'hFFF4, 4'b0111, 4'hF, 3'b111},
        {16'h0009, 4'b1101, 4'h0, 3'b000}
    };
    // expected: {dev_sel_n, ctl_data, rd_en, wr_en, board_en_n, inh_ram_n, inh_rom_n}
    localparam logic [13:0] EXP [NV] = '{
        {8'hFF, 4'b0001, 2'b11},  // idle
        {8'hF7, 4'b0100, 2'b11},  // R2 R7 io read dev3
        {8'h7F, 4'b1010, 2'b11},  // R2 R3 R8 io write dev7
        {8'hFF, 4'b0001, 2'b11},  // R1 base miss read
        {8'hFF, 4'b1011, 2'b11},  // R8 write unqualified on miss
        {8'hFF, 4'b0001, 2'b11},  // R4 mem read in direct mode
        {8'hFD, 4'b0100, 2'b11},  // R5 mem read in window
        {8'hFF, 4'b0001, 2'b11},  // R5 upper byte FE blocks
        {8'hDF, 4'b1010, 2'b01},  // R5 R10 mem write, ram inhibit
        {8'hFF, 4'b0001, 2'b10},  // R10 rom inhibit only
        {8'hFE, 4'b0100, 2'b11},  // R6 io read outside window in mmio
        {8'hFB, 4'b0100, 2'b00},  // R10 both inhibits, base F
        {8'hEF, 4'b1100, 2'b11}   // R1 base 0, dev4
    };

    task automatic apply(input logic [26:0] s);
        {addr, mem_rd_n, mem_wr_n, io_rd_n, io_wr_n, base_cfg, mmio_mode, inh_ram_en, inh_rom_en} = s;
    endtask

    task automatic check(input string req, input logic [13:0] act, input logic [13:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    function automatic logic [13:0] outs();
        return {dev_sel_n, ctl_data, rd_en, wr_en, board_en_n, inh_ram_n, inh_rom_n};
    endfunction

    initial begin
        #(20 * 200000);
        if (!done) begin
            fails++;
            checks++;
            $display("FAIL watchdog: actual hung expected done");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        #2;
        // reset state: idle bus gives no select, no enable
        check("R2 reset", outs(), {8'hFF, 4'b0001, 2'b11});

        // table walk; each check lands mid-cycle with no clock edge since the change (R11)
        for (int i = 0; i < NV; i++) begin
            @(negedge clk);
            apply(STIM[i]);
            #2;
            check($sformatf("R11 vector %0d", i), outs(), EXP[i]);
            check($sformatf("R9 vector %0d", i),
                  {12'd0, buf_cs_n, buf_to_bus}, {12'd0, board_en_n, rd_en});
        end

        // R12 select sweep: io read, base 5, every index
        for (int k = 0; k < 8; k++) begin
            @(negedge clk);
            apply({16'h0050 | 16'(k << 1), 4'b1101, 4'h5, 3'b000});
            #2;
            check($sformatf("R12 sel %0d", k), {6'd0, dev_sel_n}, {6'd0, ~(8'h01 << k)});
        end

        // R1 base sweep: only nibble 5 matches
        for (int b = 0; b < 16; b++) begin
            @(negedge clk);
            apply({16'h0002 | 16'(b << 4), 4'b1101, 4'h5, 3'b000});
            #2;
            check($sformatf("R1 base %0d", b), {12'd0, rd_en, board_en_n},
                  (b == 5) ? 14'b10 : 14'b01);
        end

        // R4 memory write in direct mode with all-ones upper byte: no effect
        @(negedge clk);
        apply({16'hFF5E, 4'b1011, 4'h5, 3'b011});
        #2;
        check("R4 mem write direct", outs(), {8'hFF, 4'b0001, 2'b11});

        // R12 no select while idle even with address on base
        @(negedge clk);
        apply({16'hFF5E, 4'b1111, 4'h5, 3'b111});
        #2;
        check("R12 idle no select", {6'd0, dev_sel_n}, {6'd0, 8'hFF});

        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule